// File: doc/BRIEF.md
# Relative-Jump Program Counter

This block holds the address of the next instruction to fetch and works out the following address every cycle. A fetch unit drives three control strobes and a signed-or-unsigned 16-bit displacement. The strobes are step by one, jump forward by the displacement, and jump backward by the displacement. The block combines them with the current count through purely combinational logic. The result is captured on the next rising clock edge. A new operation can therefore be issued on every cycle, back to back, with no stall.

The control inputs are plain level pins with no handshake. The block always accepts one operation per cycle and never applies back-pressure. Callers are expected to raise at most one strobe per cycle. If several are raised, a fixed priority keeps the outcome deterministic. All arithmetic wraps at the register width. There is no carry or borrow output.

Top module: `pc_relative_seq`

## Requirements
- R1: Reset is synchronous and active high, and it overrides every strobe. One edge after `rst` is sampled high, `pc_q` reads 0x0000.
- R2: When `step_en` is high, `pc_q` increases by exactly one at the next edge. `fwd_en`, `back_en` and `disp` have no effect in that cycle.
- R3: When `fwd_en` is high and `step_en` is low, `pc_q` becomes its previous value plus `disp` at the next edge.
- R4: When `back_en` is the only strobe high, `pc_q` becomes its previous value minus `disp` at the next edge.
- R5: When no strobe is high and reset is low, `pc_q` keeps its value across the edge.
- R6: Each operation is visible on `pc_q` exactly one edge after it is presented. Operations issued on consecutive cycles each take effect in turn.
- R7: All results are taken modulo 2^16. 0xFFFF stepped gives 0x0000, 0x0000 minus 1 gives 0xFFFF, and forward sums that pass 0xFFFF keep only the low 16 bits.
- R8: If several strobes are high together, step wins over forward, and forward wins over backward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the count by one |
| fwd_en | input | 1 | Add `disp` to the count |
| back_en | input | 1 | Subtract `disp` from the count |
| disp | input | 16 | Relative jump displacement |
| pc_q | output | 16 | Current program counter value |

## Verification
The bench goes after the wrap points at both ends of the range. A design with a wider internal sum or a mishandled borrow would show 0x10000 truncated wrongly, or a stale value, at 0xFFFF+1 and 0x0000-1. It also raises several strobes at once, together with a nonzero displacement. A wrong priority or an offset leaking into the step path would give a jump where a step of one is due. It asserts reset in the middle of a run of steps, which catches a reset that is asynchronous or ranked below the strobes. Long random back-to-back streams expose any extra pipeline stage, because such a design would lag the reference by a cycle.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_FWD  = 2'd2,
    OP_BACK = 2'd3
  } pc_op_e;
endpackage

// File: rtl/pc_op_select.sv
module pc_op_select
  import pc_seq_pkg::*;
(
  input  logic   step_en,
  input  logic   fwd_en,
  input  logic   back_en,
  output pc_op_e op
);
  // Fixed priority: step, then forward, then backward (R8)
  always_comb begin
    if (step_en)      op = OP_STEP;
    else if (fwd_en)  op = OP_FWD;
    else if (back_en) op = OP_BACK;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import pc_seq_pkg::*;
#(
  parameter int  W          = 16,
  parameter bit  SHARED_ADD = 1'b1
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] disp,
  input  pc_op_e       op,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  generate
    if (SHARED_ADD) begin : g_shared
      // One adder: operand mux plus carry-in forms step, add and subtract
      logic [W-1:0] opnd;
      logic [W-1:0] cin;
      always_comb begin
        unique case (op)
          OP_STEP: begin opnd = ONE;   cin = ZERO; end
          OP_FWD:  begin opnd = disp;  cin = ZERO; end
          OP_BACK: begin opnd = ~disp; cin = ONE;  end
          default: begin opnd = ZERO;  cin = ZERO; end
        endcase
      end
      assign nxt = cur + opnd + cin;
    end else begin : g_split
      // Three parallel datapaths, result chosen after the arithmetic
      logic [W-1:0] inc_v, add_v, sub_v;
      assign inc_v = cur + ONE;
      assign add_v = cur + disp;
      assign sub_v = cur - disp;
      always_comb begin
        unique case (op)
          OP_STEP: nxt = inc_v;
          OP_FWD:  nxt = add_v;
          OP_BACK: nxt = sub_v;
          default: nxt = cur;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (q == '0)); // R1
endmodule

// File: rtl/pc_relative_seq.sv
module pc_relative_seq
  import pc_seq_pkg::*;
#(
  parameter int W          = 16,
  parameter bit SHARED_ADD = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         fwd_en,
  input  logic         back_en,
  input  logic [W-1:0] disp,
  output logic [W-1:0] pc_q
);
  pc_op_e       op;
  logic [W-1:0] pc_next;

  pc_op_select u_sel (
    .step_en (step_en),
    .fwd_en  (fwd_en),
    .back_en (back_en),
    .op      (op)
  );

  pc_next_calc #(.W(W), .SHARED_ADD(SHARED_ADD)) u_calc (
    .cur  (pc_q),
    .disp (disp),
    .op   (op),
    .nxt  (pc_next)
  );

  pc_state_reg #(.W(W)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (pc_next),
    .q   (pc_q)
  );

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (pc_q == W'($past(pc_q) + W'(1)))); // R2
  AST_FWD_JUMP: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && !step_en) |=> (pc_q == W'($past(pc_q) + $past(disp)))); // R3
  AST_BACK_JUMP: assert property (@(posedge clk) disable iff (rst)
    (back_en && !fwd_en && !step_en) |=> (pc_q == W'($past(pc_q) - $past(disp)))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !fwd_en && !back_en) |=> $stable(pc_q)); // R5
endmodule

// File: tb/tb_pc_relative_seq.sv
`timescale 1ns/1ps
module tb_pc_relative_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0, fwd_en = 1'b0, back_en = 1'b0;
  logic [15:0] disp = '0;
  logic [15:0] pc_q;

  int checks = 0;
  int errors = 0;
  logic [15:0] model = '0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pc_relative_seq dut (
    .clk(clk), .rst(rst), .step_en(step_en), .fwd_en(fwd_en),
    .back_en(back_en), .disp(disp), .pc_q(pc_q)
  );

  function automatic logic [15:0] ref_next(logic [15:0] cur, logic r, logic s,
                                           logic f, logic b, logic [15:0] d);
    if (r)      return 16'h0000;
    else if (s) return cur + 16'd1;
    else if (f) return cur + d;
    else if (b) return cur - d;
    else        return cur;
  endfunction

  // Driver: apply one operation at the falling edge and queue its expected result
  task automatic drive(logic r, logic s, logic f, logic b, logic [15:0] d, string tag);
    @(negedge clk);
    rst = r; step_en = s; fwd_en = f; back_en = b; disp = d;
    model = ref_next(model, r, s, f, b, d);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // Monitor: one edge after each operation, compare against the queue head
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pc_q !== e) begin
        errors++;
        $display("FAIL %s: pc_q=%h expected=%h", t, pc_q, e);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(1, 0, 0, 0, 16'h0000, "R1 reset value");
    drive(0, 0, 0, 0, 16'h1234, "R5 idle after reset");
    drive(0, 1, 0, 0, 16'h0000, "R2 step");
    drive(0, 1, 0, 0, 16'h7777, "R2 step ignores disp");
    drive(0, 0, 1, 0, 16'h0100, "R3 forward jump");
    drive(0, 0, 0, 1, 16'h0040, "R4 backward jump");
    drive(0, 0, 0, 0, 16'hFFFF, "R5 hold");
    drive(0, 0, 0, 0, 16'h0000, "R5 hold again");
    drive(0, 1, 1, 1, 16'h0F00, "R8 R2 step beats jumps");
    drive(0, 0, 1, 1, 16'h0010, "R8 forward beats backward");
    drive(0, 1, 0, 0, 16'h0000, "R1 step before reset");
    drive(1, 1, 0, 0, 16'h0000, "R1 reset overrides step");
    drive(0, 0, 0, 1, 16'h0001, "R7 zero minus one");
    drive(0, 1, 0, 0, 16'h0000, "R7 max plus one");
    drive(0, 0, 1, 0, 16'hFFF0, "R3 forward large");
    drive(0, 0, 1, 0, 16'h0020, "R7 forward wrap");
    drive(0, 0, 0, 1, 16'h0030, "R7 backward wrap");
    for (int i = 0; i < 400; i++) begin
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 4));
      drive(i % 97 == 96, pick == 1, pick == 2, pick == 3,
            16'($urandom), "R6 back-to-back stream");
    end
    drive(0, 0, 0, 0, 16'h0000, "R5 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule